// File: doc/BRIEF.md
# PLL Divider Code Decoder

This block converts the encoded divider fields of a PLL configuration into plain integer values. The configuration does not keep its pre-divider, post-divider and multiplier in binary. Each value is kept as a state of a field-specific linear feedback shift register (LFSR). A few small values have fixed codes of their own. To recover the integer, the decoder runs the field's LFSR from a fixed seed. It counts a candidate index down from the field's upper bound and stops at the first state that equals the code.

A request carries a 2-bit field select and a 17-bit code on a valid/ready handshake. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the decoder is idle, so a request presented while busy is not taken. The requester must hold it until `in_ready` returns. The result side has no back-pressure: `out_valid` is a one-cycle pulse, and the result is captured in that cycle. The result comes with the effective divider value and an invalid flag. A new request may be accepted in the same cycle as the pulse.

The search performs one LFSR step and one compare per clock. The worst case is about 32766 cycles, for a multiplier code that matches nothing.

Top module: `pll_code_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` and `busy` are 0 and `in_ready` is 1.
- R2: A request is accepted only when `in_valid` and `in_ready` are high together. `in_ready` is 0 and `busy` is 1 from the cycle after acceptance until the cycle of `out_valid`. A request presented while busy produces no result and does not change the request in progress.
- R3: Field select encoding is 0 = pre-divider, 1 = post-divider, 2 = multiplier. Fixed codes decode to 0, 1 and 2 in this order: pre-divider 0x3FF, 0x302, 0x202; post-divider 0x7F, 0x62, 0x42; multiplier 0x1FFFF, 0x18003, 0x10003. Their result appears one cycle after acceptance.
- R4: Pre-divider search: 8-bit state with seed 0x80. Each step shifts the state right by one and loads bit 7 with the XOR of old bits 0, 2, 3 and 4. The candidate index starts at 256.
- R5: Post-divider search: 5-bit state with seed 0x10. The new bit 4 is the XOR of old bits 0 and 2. The index starts at 32.
- R6: Multiplier search: 15-bit state with seed 0x4000. The new bit 14 is the XOR of old bits 0 and 1. The index starts at 32768.
- R7: Each search cycle advances the state and then compares the new state, zero-extended, with the masked code. The result is the index of the first match, with the index decremented after each miss. A match after j steps gives `out_valid` j+1 cycles after acceptance.
- R8: If no state matches down to index 3, `out_invalid` is 1, and `out_result` and `out_eff` are all ones (0xFFFF). This arrives top-1 cycles after acceptance.
- R9: For valid results, `out_eff` equals the result for the pre-divider and the multiplier, with 0 replaced by 1. For the post-divider it is twice the result, with 2 when the result is 0.
- R10: Field select 3 gives an invalid result one cycle after acceptance.
- R11: `out_valid` is high for exactly one cycle per accepted request.
- R12: Only the low 10, 7 or 17 code bits are used for the pre-divider, post-divider and multiplier respectively. Higher bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Decoder idle, request can be taken |
| in_sel | input | 2 | Field select (0 pre, 1 post, 2 multiplier, 3 none) |
| in_code | input | 17 | Encoded divider field |
| busy | output | 1 | A request is being decoded |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 16 | Decoded index, or 0xFFFF if invalid |
| out_eff | output | 16 | Effective divider value |
| out_invalid | output | 1 | No state matched, or field select 3 |

## Verification
The bench targets the ends of each search range: the first step (index equal to the upper bound), the last index 3, and codes with bits above the state width, which can never match. An off-by-one in the index counter or the stop condition would shift every result and its latency by one, and a wrong tap would decode to unrelated indices. Fixed codes are also sent with junk in the upper bits. Back-to-back requests are issued in the cycle of the result strobe. A second request is pushed while a long multiplier search is running. A decoder that accepted that request, or that let a ready/strobe race through, would produce an extra or altered result, and the scoreboard catches it. Post-divider results are checked for the doubled effective value and the 0-to-2 substitution.

// File: rtl/pll_dec_pkg.sv
`timescale 1ns/1ps
package pll_dec_pkg;

  typedef enum logic [1:0] {
    SEL_PRE  = 2'd0,
    SEL_POST = 2'd1,
    SEL_MUL  = 2'd2,
    SEL_NONE = 2'd3
  } dec_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_SEARCH = 2'd2
  } dec_state_e;

  localparam int NUM_FIELDS  = 3;
  localparam int NUM_FIXED   = 3;
  localparam int MAX_CODE_W  = 17;
  localparam int MAX_STATE_W = 15;

  // encoded field width per field
  function automatic int fld_code_w(input int f);
    case (f)
      0:       return 10;
      1:       return 7;
      default: return 17;
    endcase
  endfunction

  // LFSR state width per field
  function automatic int fld_state_w(input int f);
    case (f)
      0:       return 8;
      1:       return 5;
      default: return 15;
    endcase
  endfunction

  function automatic int fld_seed(input int f);
    case (f)
      0:       return 'h80;
      1:       return 'h10;
      default: return 'h4000;
    endcase
  endfunction

  // feedback taps: XOR of the marked bits enters the top bit
  function automatic int fld_taps(input int f);
    case (f)
      0:       return 'h1D;
      1:       return 'h05;
      default: return 'h0003;
    endcase
  endfunction

  // first candidate index of the search
  function automatic int fld_top(input int f);
    case (f)
      0:       return 256;
      1:       return 32;
      default: return 32768;
    endcase
  endfunction

  // fixed codes; entry k decodes to value k
  function automatic int fld_fixed(input int f, input int k);
    case (f)
      0: case (k)
           0:       return 'h3FF;
           1:       return 'h302;
           default: return 'h202;
         endcase
      1: case (k)
           0:       return 'h7F;
           1:       return 'h62;
           default: return 'h42;
         endcase
      default: case (k)
           0:       return 'h1FFFF;
           1:       return 'h18003;
           default: return 'h10003;
         endcase
    endcase
  endfunction

endpackage

// File: rtl/pll_dec_lfsr.sv
`timescale 1ns/1ps
module pll_dec_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] next_o
);
  logic [W-1:0] st_q;

  // shift right, feedback into the top bit
  assign next_o = {^(st_q & TAPS), st_q[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= SEED;
    else if (load) st_q <= SEED;
    else if (adv)  st_q <= next_o;
  end
endmodule

// File: rtl/pll_dec_fixed.sv
`timescale 1ns/1ps
module pll_dec_fixed
  import pll_dec_pkg::*;
#(
  parameter int CODE_W = 17
) (
  input  dec_sel_e          sel,
  input  logic [CODE_W-1:0] code,
  output logic              hit,
  output logic [1:0]        value
);
  logic [NUM_FIXED-1:0] hit_vec;

  for (genvar k = 0; k < NUM_FIXED; k++) begin : g_ent
    assign hit_vec[k] = (sel != SEL_NONE) &&
                        (code == CODE_W'(fld_fixed(int'(sel), k)));
  end

  assign hit = |hit_vec;

  always_comb begin
    value = 2'd0;
    for (int k = NUM_FIXED - 1; k >= 0; k--) begin
      if (hit_vec[k]) value = 2'(k);
    end
  end
endmodule

// File: rtl/pll_dec_eff.sv
`timescale 1ns/1ps
module pll_dec_eff
  import pll_dec_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  dec_sel_e         sel,
  input  logic [RES_W-1:0] result,
  input  logic             invalid,
  output logic [RES_W-1:0] eff
);
  always_comb begin
    if (invalid) begin
      eff = '1;
    end else if (sel == SEL_POST) begin
      eff = (result == '0) ? RES_W'(2) : {result[RES_W-2:0], 1'b0};
    end else begin
      eff = (result == '0) ? RES_W'(1) : result;
    end
  end
endmodule

// File: rtl/pll_dec_ctrl.sv
`timescale 1ns/1ps
module pll_dec_ctrl
  import pll_dec_pkg::*;
#(
  parameter int CODE_W = 17,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_sel,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  output logic              busy,
  output dec_sel_e          sel_q,
  output logic [CODE_W-1:0] code_q,
  output logic              lfsr_load,
  output logic              lfsr_adv,
  input  logic [CODE_W-1:0] cand,
  input  logic              fixed_hit,
  input  logic [1:0]        fixed_val,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_result,
  output logic              out_invalid
);
  localparam logic [RES_W-1:0] LAST_IDX = RES_W'(3);

  dec_state_e       st_q;
  logic [RES_W-1:0] idx_q;
  logic [CODE_W-1:0] in_mask;

  assign in_ready  = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign lfsr_load = (st_q == ST_CHECK);
  assign lfsr_adv  = (st_q == ST_SEARCH);
  assign in_mask   = (CODE_W'(1) << fld_code_w(int'(in_sel))) - CODE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      sel_q       <= SEL_NONE;
      code_q      <= '0;
      idx_q       <= '0;
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            sel_q  <= dec_sel_e'(in_sel);
            code_q <= in_code & in_mask;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (sel_q == SEL_NONE) begin
            out_valid   <= 1'b1;
            out_result  <= '1;
            out_invalid <= 1'b1;
            st_q        <= ST_IDLE;
          end else if (fixed_hit) begin
            out_valid   <= 1'b1;
            out_result  <= RES_W'(fixed_val);
            out_invalid <= 1'b0;
            st_q        <= ST_IDLE;
          end else begin
            idx_q <= RES_W'(fld_top(int'(sel_q)));
            st_q  <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (cand == code_q) begin
            out_valid   <= 1'b1;
            out_result  <= idx_q;
            out_invalid <= 1'b0;
            st_q        <= ST_IDLE;
          end else if (idx_q == LAST_IDX) begin
            out_valid   <= 1'b1;
            out_result  <= '1;
            out_invalid <= 1'b1;
            st_q        <= ST_IDLE;
          end else begin
            idx_q <= idx_q - RES_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_code_decoder.sv
`timescale 1ns/1ps
module pll_code_decoder
  import pll_dec_pkg::*;
#(
  parameter int CODE_W = MAX_CODE_W,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_sel,
  input  logic [CODE_W-1:0] in_code,
  output logic              busy,
  output logic              out_valid,
  output logic [RES_W-1:0]  out_result,
  output logic [RES_W-1:0]  out_eff,
  output logic              out_invalid
);
  dec_sel_e          sel_q;
  logic [CODE_W-1:0] code_q;
  logic              lfsr_load;
  logic              lfsr_adv;
  logic [CODE_W-1:0] cand;
  logic              fixed_hit;
  logic [1:0]        fixed_val;
  logic [CODE_W-1:0] nxt_all [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int SW = fld_state_w(g);
    logic [SW-1:0] nxt;
    pll_dec_lfsr #(
      .W   (SW),
      .SEED(SW'(fld_seed(g))),
      .TAPS(SW'(fld_taps(g)))
    ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (lfsr_load),
      .adv   (lfsr_adv && (int'(sel_q) == g)),
      .next_o(nxt)
    );
    assign nxt_all[g] = {{(CODE_W-SW){1'b0}}, nxt};
  end

  always_comb begin
    cand = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (int'(sel_q) == f) cand = nxt_all[f];
    end
  end

  pll_dec_fixed #(.CODE_W(CODE_W)) u_fixed (
    .sel  (sel_q),
    .code (code_q),
    .hit  (fixed_hit),
    .value(fixed_val)
  );

  pll_dec_ctrl #(.CODE_W(CODE_W), .RES_W(RES_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sel     (in_sel),
    .in_code    (in_code),
    .in_ready   (in_ready),
    .busy       (busy),
    .sel_q      (sel_q),
    .code_q     (code_q),
    .lfsr_load  (lfsr_load),
    .lfsr_adv   (lfsr_adv),
    .cand       (cand),
    .fixed_hit  (fixed_hit),
    .fixed_val  (fixed_val),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_invalid(out_invalid)
  );

  pll_dec_eff #(.RES_W(RES_W)) u_eff (
    .sel    (sel_q),
    .result (out_result),
    .invalid(out_invalid),
    .eff    (out_eff)
  );
endmodule

// File: rtl/pll_dec_chk.sv
`timescale 1ns/1ps
module pll_dec_chk #(
  parameter int CODE_W = 17,
  parameter int RES_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              busy,
  input logic              out_valid,
  input logic [RES_W-1:0]  out_result,
  input logic [RES_W-1:0]  out_eff,
  input logic              out_invalid,
  input logic [CODE_W-1:0] code_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !busy));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R2
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(code_q));

  // R3
  fixed_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid && (out_result <= RES_W'(2)))
      |-> $past(in_valid && in_ready, 2));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy);

  // R8
  invalid_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> ((&out_result) && (&out_eff)));

  // R9
  eff_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid) |-> (out_eff != '0));

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

bind pll_code_decoder pll_dec_chk #(.CODE_W(CODE_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_eff    (out_eff),
  .out_invalid(out_invalid),
  .code_q     (code_q)
);

// File: tb/sim_pll_code_decoder.sv
`timescale 1ns/1ps
module sim_pll_code_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_sel = 2'd0;
  logic [16:0] in_code = '0;
  logic        busy;
  logic        out_valid;
  logic [15:0] out_result;
  logic [15:0] out_eff;
  logic        out_invalid;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;
  bit prev_ov  = 0;

  typedef struct {
    logic [15:0] res;
    logic [15:0] eff;
    logic        inv;
    int          done_cyc;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pll_code_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sel     (in_sel),
    .in_code    (in_code),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_eff    (out_eff),
    .out_invalid(out_invalid)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic int m_cw(input int f);
    return (f == 0) ? 10 : (f == 1) ? 7 : 17;
  endfunction
  function automatic int m_seed(input int f);
    return (f == 0) ? 'h80 : (f == 1) ? 'h10 : 'h4000;
  endfunction
  function automatic int m_top(input int f);
    return (f == 0) ? 256 : (f == 1) ? 32 : 32768;
  endfunction
  function automatic int m_fixed(input int f, input int k);
    int t0[3] = '{'h3FF, 'h302, 'h202};
    int t1[3] = '{'h7F, 'h62, 'h42};
    int t2[3] = '{'h1FFFF, 'h18003, 'h10003};
    return (f == 0) ? t0[k] : (f == 1) ? t1[k] : t2[k];
  endfunction
  // R4 R5 R6 single steps
  function automatic int m_step(input int f, input int s);
    if (f == 0) return int'({s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]});
    if (f == 1) return int'({s[0] ^ s[2], s[4:1]});
    return int'({s[0] ^ s[1], s[14:1]});
  endfunction

  function automatic int m_encode(input int f, input int idx);
    int s = m_seed(f);
    for (int i = m_top(f); i >= idx; i--) s = m_step(f, s);
    return s;
  endfunction

  task automatic m_decode(input int f, input int code, output int res,
                          output int lat, output bit inv);
    int m;
    int s;
    inv = 0;
    lat = 1;
    res = 'hFFFF;
    if (f == 3) begin
      inv = 1;
      return;
    end
    m = code & ((1 << m_cw(f)) - 1);
    for (int k = 0; k < 3; k++) begin
      if (m == m_fixed(f, k)) begin
        res = k;
        return;
      end
    end
    s = m_seed(f);
    for (int i = m_top(f); i >= 3; i--) begin
      s = m_step(f, s);
      lat++;
      if (s == m) begin
        res = i;
        return;
      end
    end
    inv = 1;
    res = 'hFFFF;
  endtask

  // ---------------- driver ----------------
  // called at a falling edge; returns at a falling edge
  task automatic send(input int f, input int code, input string tag);
    exp_t e;
    int   res;
    int   lat;
    bit   inv;
    while (!in_ready) @(negedge clk);
    m_decode(f, code, res, lat, inv);
    e.res = 16'(res);
    e.inv = inv;
    if (inv) e.eff = 16'hFFFF;
    else if (f == 1) e.eff = (res == 0) ? 16'd2 : 16'(2 * res);
    else e.eff = (res == 0) ? 16'd1 : 16'(res);
    e.done_cyc = cyc + 1 + lat;
    e.tag = tag;
    sb_q.push_back(e);
    in_valid = 1'b1;
    in_sel   = 2'(f);
    in_code  = 17'(code);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (prev_ov) begin
        n_checks++;
        if (out_valid) begin
          n_fail++;
          $display("FAIL R11 out_valid held: actual=1 expected=0");
        end
      end
      if (out_valid) begin
        n_checks++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected result: actual=%0h expected=none", out_result);
        end else begin
          e = sb_q.pop_front();
          if (out_result !== e.res || out_eff !== e.eff ||
              out_invalid !== e.inv || cyc != e.done_cyc) begin
            n_fail++;
            $display("FAIL %s (R7 timing) res=%0h/%0h eff=%0h/%0h inv=%0b/%0b cycle=%0d/%0d (actual/expected)",
                     e.tag, out_result, e.res, out_eff, e.eff,
                     out_invalid, e.inv, cyc, e.done_cyc);
          end
        end
      end
      prev_ov = out_valid;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog expired: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_checks++;
    if (out_valid !== 1'b0 || busy !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 in reset: actual ov=%0b busy=%0b rdy=%0b expected 0 0 1",
               out_valid, busy, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || busy !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 after reset: actual ov=%0b busy=%0b rdy=%0b expected 0 0 1",
               out_valid, busy, in_ready);
    end

    // R3 R9 fixed codes, back-to-back
    for (int f = 0; f < 3; f++)
      for (int k = 0; k < 3; k++)
        send(f, m_fixed(f, k), "R3,R9");

    // R4 pre-divider search ends
    send(0, m_encode(0, 256), "R4,R9");
    send(0, m_encode(0, 130), "R4,R9");
    send(0, m_encode(0, 3), "R4,R9");
    // R5 post-divider search ends
    send(1, m_encode(1, 32), "R5,R9");
    send(1, m_encode(1, 17), "R5,R9");
    send(1, m_encode(1, 3), "R5,R9");
    // R6 multiplier
    send(2, m_encode(2, 32768), "R6,R9");
    send(2, m_encode(2, 20000), "R6,R9");

    // R8 codes that cannot match
    send(0, 'h300, "R8");
    send(1, 'h60, "R8");
    send(2, 'h18000, "R8");

    // R10 field select 3
    send(3, 0, "R10");

    // R12 upper bits ignored
    send(0, 'h3FF | 'h1000, "R12");
    send(1, 'h42 | 'h80, "R12");
    send(1, m_encode(1, 17) | 'h100, "R12");

    // R2 request while busy is ignored
    send(2, m_encode(2, 30000), "R2,R6");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      n_checks++;
      if (in_ready !== 1'b0 || busy !== 1'b1) begin
        n_fail++;
        $display("FAIL R2 while busy: actual rdy=%0b busy=%0b expected 0 1",
                 in_ready, busy);
      end
      in_valid = 1'b1;
      in_sel   = 2'd0;
      in_code  = 17'h3FF;
    end
    @(negedge clk);
    in_valid = 1'b0;

    while (sb_q.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule